// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Idle-Line Wakeup

This block receives asynchronous serial characters on a single line, oversampling it sixteen times per bit. Two word layouts are supported: a ten-bit frame (start, eight data bits, stop) and an eleven-bit frame that carries a ninth data bit before the stop bit, as used on shared multi-node lines. Received characters land in a data register with a full flag and a receive interrupt.

A node on a shared line can put the receiver to sleep with a one-cycle request. While asleep, complete characters are discarded and the data register keeps its contents. The receiver separately watches for a run of high samples as long as one whole frame. When it sees one, it raises an idle status flag and a pending idle interrupt flag, and (when idle-line wakeup is selected) it wakes itself, so the node reads the next message from its first character. The idle status flag drops on the next valid start bit, and the detector fires only once per idle stretch.

Top module: `rxw_idle_wake`

## Requirements
- R1: In ten-bit format (`fmt11`=0) a frame is one low start bit, eight data bits sent least significant first, and one high stop bit. An awake receiver stores the byte in `rx_data[7:0]`, clears `rx_data[8]` and sets `rx_full`.
- R2: In eleven-bit format (`fmt11`=1) a ninth data bit follows the eighth data bit and is stored in `rx_data[8]`.
- R3: A start bit is accepted only if the line is still low eight sample ticks after the first low sample. A shorter low pulse yields no character.
- R4: `rx_irq` is high exactly when `rie` and `rx_full` are both high. A pulse on `rd_ack` clears `rx_full`.
- R5: A pulse on `rwu_set` sets `sleeping`. Characters completed while asleep leave `rx_full` and `rx_data` unchanged.
- R6: After 16×10 consecutive high sample ticks (ten-bit format) or 16×11 (eleven-bit format), `idle_flag` and `idle_pend` are set.
- R7: On idle detection with `wake_sel`=0, `sleeping` is cleared. With `wake_sel`=1 it stays set.
- R8: `idle_irq` is high exactly when `ilie` and `idle_pend` are both high. A pulse on `idle_ack` clears `idle_pend`.
- R9: `idle_flag` clears on the next accepted start bit. Only that start bit re-arms detection, so a single idle stretch gives one detection.
- R10: Any low sample restarts the idle count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, high when idle |
| fmt11 | input | 1 | 0: ten-bit frames, 1: eleven-bit frames |
| wake_sel | input | 1 | 0: idle-line wakeup enabled, 1: idle does not wake |
| rwu_set | input | 1 | One-cycle pulse that puts the receiver to sleep |
| rie | input | 1 | Receive interrupt enable |
| ilie | input | 1 | Idle interrupt enable |
| rd_ack | input | 1 | Pulse that clears the data-full flag |
| idle_ack | input | 1 | Pulse that clears the pending idle flag |
| rx_data | output | 9 | Last character accepted while awake |
| rx_full | output | 1 | Data register holds an unread character |
| sleeping | output | 1 | Receiver is asleep |
| idle_flag | output | 1 | Idle line seen since the last start bit |
| idle_pend | output | 1 | Pending idle interrupt flag |
| rx_irq | output | 1 | Receive interrupt |
| idle_irq | output | 1 | Idle interrupt |

## Verification
The assertions assume that `rwu_set` never lands in the same cycle as an idle detection. They also assume that `fmt11` changes only while the line is high and no frame is in progress, so the frame length used by the detector matches the frame on the line. The stimulus changes the format only just before it drives a start bit, and it issues sleep requests only at least a bit time away from any detection. Every low pulse the bench drives is either a whole frame or a glitch of two sample ticks, well under the start-bit validation point.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  localparam int OSR = 16;
  localparam logic [3:0] MID_TICK = 4'(OSR / 2 - 1);
  localparam logic [3:0] LAST_TICK = 4'(OSR - 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_t;

  function automatic logic [3:0] frame_len(input logic f11);
    return f11 ? 4'd11 : 4'd10;
  endfunction

  function automatic logic [3:0] data_len(input logic f11);
    return f11 ? 4'd9 : 4'd8;
  endfunction
endpackage

// File: rtl/rxw_tick_gen.sv
module rxw_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int W = $clog2(DIV);
      logic [W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else if (cnt == W'(DIV - 1)) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == W'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/rxw_sync.sv
module rxw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else chain <= {chain[STAGES-2:0], din};
  end
  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rxw_frame_rx.sv
module rxw_frame_rx
  import rxw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx,
  input  logic       fmt11,
  output logic       start_ok,
  output logic       char_done,
  output logic [8:0] word
);
  rx_state_t  st;
  logic [3:0] os;
  logic [3:0] idx;
  logic       f11_q;
  logic [8:0] shreg;

  assign start_ok  = tick && (st == ST_START) && (os == MID_TICK) && !rx;
  assign char_done = tick && (st == ST_STOP) && (os == LAST_TICK);
  assign word      = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      os    <= '0;
      idx   <= '0;
      f11_q <= 1'b0;
      shreg <= '0;
    end else if (tick) begin
      case (st)
        ST_IDLE: begin
          os <= '0;
          if (!rx) st <= ST_START;
        end
        ST_START: begin
          if (os == MID_TICK) begin
            os <= '0;
            if (!rx) begin
              st    <= ST_DATA;
              idx   <= '0;
              f11_q <= fmt11;
              shreg <= '0;
            end else begin
              st <= ST_IDLE;
            end
          end else begin
            os <= os + 1'b1;
          end
        end
        ST_DATA: begin
          if (os == LAST_TICK) begin
            os         <= '0;
            shreg[idx] <= rx;
            if (idx == data_len(f11_q) - 4'd1) st <= ST_STOP;
            else idx <= idx + 1'b1;
          end else begin
            os <= os + 1'b1;
          end
        end
        default: begin
          if (os == LAST_TICK) begin
            os <= '0;
            st <= ST_IDLE;
          end else begin
            os <= os + 1'b1;
          end
        end
      endcase
    end
  end

  // R3: a validated start always leads into data reception
  p_start_enters_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (st == ST_DATA));
endmodule

// File: rtl/rxw_idle_det.sv
module rxw_idle_det
  import rxw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx,
  input  logic fmt11,
  input  logic rearm,
  output logic idle_hit
);
  logic [3:0] phase;
  logic [3:0] bits;
  logic       armed;
  logic [3:0] flen;

  assign flen = frame_len(fmt11);
  assign idle_hit = tick && rx && armed && (phase == LAST_TICK) &&
                    (bits == flen - 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      bits  <= '0;
      armed <= 1'b1;
    end else begin
      if (tick) begin
        if (!rx) begin
          phase <= '0;
          bits  <= '0;
        end else if (phase == LAST_TICK) begin
          phase <= '0;
          if (bits < flen) bits <= bits + 1'b1;
        end else begin
          phase <= phase + 1'b1;
        end
      end
      if (rearm) armed <= 1'b1;
      else if (idle_hit) armed <= 1'b0;
    end
  end

  // R10: a low sample always restarts the count
  p_low_restarts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !rx) |=> (bits == 4'd0));
  // R9: detection fires once and needs a start before firing again
  p_single_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_hit && !rearm) |=> !armed);
endmodule

// File: rtl/rxw_idle_wake.sv
module rxw_idle_wake
  import rxw_pkg::*;
#(
  parameter int SAMP_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       fmt11,
  input  logic       wake_sel,
  input  logic       rwu_set,
  input  logic       rie,
  input  logic       ilie,
  input  logic       rd_ack,
  input  logic       idle_ack,
  output logic [8:0] rx_data,
  output logic       rx_full,
  output logic       sleeping,
  output logic       idle_flag,
  output logic       idle_pend,
  output logic       rx_irq,
  output logic       idle_irq
);
  logic       tick;
  logic       rx_s;
  logic       start_ok;
  logic       char_done;
  logic       idle_hit;
  logic [8:0] word;

  rxw_tick_gen #(.DIV(SAMP_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  rxw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s));

  rxw_frame_rx u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_s), .fmt11(fmt11),
    .start_ok(start_ok), .char_done(char_done), .word(word));

  rxw_idle_det u_idle (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx(rx_s), .fmt11(fmt11),
    .rearm(start_ok), .idle_hit(idle_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      rx_full   <= 1'b0;
      sleeping  <= 1'b0;
      idle_flag <= 1'b0;
      idle_pend <= 1'b0;
    end else begin
      if (char_done && !sleeping) begin
        rx_data <= word;
        rx_full <= 1'b1;
      end else if (rd_ack) begin
        rx_full <= 1'b0;
      end
      if (rwu_set) sleeping <= 1'b1;
      else if (idle_hit && !wake_sel) sleeping <= 1'b0;
      if (idle_hit) idle_flag <= 1'b1;
      else if (start_ok) idle_flag <= 1'b0;
      if (idle_hit) idle_pend <= 1'b1;
      else if (idle_ack) idle_pend <= 1'b0;
    end
  end

  assign rx_irq   = rie & rx_full;
  assign idle_irq = ilie & idle_pend;

  p_idle_sets_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idle_hit |=> (idle_flag && idle_pend));
  p_idle_wakes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_hit && !wake_sel && !rwu_set) |=> !sleeping);
  p_start_clears_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && !idle_hit) |=> !idle_flag);
  p_sleep_holds_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && char_done) |=> $stable(rx_data));
  p_awake_char_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && !sleeping) |=> rx_full);
endmodule

// File: tb/rxw_idle_wake_bench.sv
module rxw_idle_wake_bench;
  localparam int DIV = 4;
  localparam int BT  = 16 * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       fmt11 = 1'b0;
  logic       wake_sel = 1'b0;
  logic       rwu_set = 1'b0;
  logic       rie = 1'b0;
  logic       ilie = 1'b0;
  logic       rd_ack = 1'b0;
  logic       idle_ack = 1'b0;
  logic [8:0] rx_data;
  logic       rx_full, sleeping, idle_flag, idle_pend, rx_irq, idle_irq;

  int  total = 0;
  int  bad = 0;
  int  hi_run = 0;
  bit  prev_idle = 0;
  bit  model_armed = 1;
  bit  cur_fmt = 0;
  bit  finished = 0;
  logic idle_after_start;

  always #10 clk = ~clk;

  rxw_idle_wake #(.SAMP_DIV(DIV)) u_rxw_idle_wake (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .fmt11(fmt11), .wake_sel(wake_sel),
    .rwu_set(rwu_set), .rie(rie), .ilie(ilie), .rd_ack(rd_ack),
    .idle_ack(idle_ack), .rx_data(rx_data), .rx_full(rx_full),
    .sleeping(sleeping), .idle_flag(idle_flag), .idle_pend(idle_pend),
    .rx_irq(rx_irq), .idle_irq(idle_irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  task automatic send_frame(input logic [8:0] d, input logic f);
    int nd;
    nd = f ? 9 : 8;
    @(negedge clk);
    fmt11 = f;
    cur_fmt = f;
    model_armed = 1;
    rxd = 1'b0;
    wait_clk(BT);
    idle_after_start = idle_flag;
    for (int i = 0; i < nd; i++) begin
      rxd = d[i];
      wait_clk(BT);
    end
    rxd = 1'b1;
    wait_clk(BT);
  endtask

  // Reference model of idle timing: counts high line clocks in the bench
  always @(negedge clk) begin
    int lim;
    #1;
    if (!rst_n) begin
      hi_run = 0;
      prev_idle = 0;
    end else begin
      if (rxd) hi_run++;
      else hi_run = 0;
      lim = (cur_fmt ? 11 : 10) * BT;
      if (idle_flag && !prev_idle) begin
        chk(hi_run >= lim - 4 && hi_run <= lim + 8, "R6 idle timing", hi_run, lim);
        model_armed = 0;
      end
      if (hi_run == lim + 12 && model_armed) begin
        chk(idle_flag, "R6 idle missing", idle_flag, 1);
        model_armed = 0;
      end
      prev_idle = idle_flag;
    end
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rx_full && !sleeping && !idle_flag && !idle_pend, "R1 reset state",
        {rx_full, sleeping, idle_flag, idle_pend}, 0);
    chk(!rx_irq && !idle_irq, "R4 reset irqs", {rx_irq, idle_irq}, 0);

    // idle after reset, irq gating
    wait_clk(11 * BT);
    chk(idle_flag && idle_pend, "R6 flags after idle", {idle_flag, idle_pend}, 3);
    chk(!idle_irq, "R8 idle_irq masked", idle_irq, 0);
    @(negedge clk); ilie = 1'b1;
    @(negedge clk);
    chk(idle_irq, "R8 idle_irq enabled", idle_irq, 1);
    pulse(idle_ack);
    @(negedge clk);
    chk(!idle_pend && !idle_irq, "R8 idle_ack clears", {idle_pend, idle_irq}, 0);
    wait_clk(20 * BT);
    chk(!idle_pend, "R9 one detection per idle", idle_pend, 0);

    // ten-bit character
    rie = 1'b1;
    send_frame(9'h0A5, 1'b0);
    chk(idle_after_start == 1'b0, "R9 start clears idle_flag", idle_after_start, 0);
    wait_clk(2);
    chk(rx_full && rx_data == 9'h0A5, "R1 ten-bit data", rx_data, 9'h0A5);
    chk(rx_irq, "R4 rx_irq with rie", rx_irq, 1);
    @(negedge clk); rie = 1'b0;
    @(negedge clk);
    chk(!rx_irq, "R4 rx_irq masked", rx_irq, 0);
    rie = 1'b1;
    pulse(rd_ack);
    @(negedge clk);
    chk(!rx_full && !rx_irq, "R4 rd_ack clears", {rx_full, rx_irq}, 0);
    wait_clk(12 * BT);
    chk(idle_flag, "R6 idle after ten-bit", idle_flag, 1);

    // eleven-bit character with ninth bit set
    send_frame(9'h13C, 1'b1);
    wait_clk(2);
    chk(rx_full && rx_data == 9'h13C, "R2 eleven-bit data", rx_data, 9'h13C);
    pulse(rd_ack);
    wait_clk(13 * BT);
    chk(idle_flag, "R6 idle after eleven-bit", idle_flag, 1);

    // glitch: rejected start, restarted idle count
    send_frame(9'h055, 1'b0);
    pulse(rd_ack);
    wait_clk(5 * BT - 2);
    rxd = 1'b0;
    wait_clk(8);
    rxd = 1'b1;
    wait_clk(4 * BT);
    chk(!idle_flag, "R10 glitch restarts idle count", idle_flag, 0);
    chk(!rx_full, "R3 short low rejected", rx_full, 0);
    wait_clk(7 * BT);
    chk(idle_flag, "R10 idle after restart", idle_flag, 1);

    // sleep with idle-line wakeup
    pulse(rwu_set);
    @(negedge clk);
    chk(sleeping, "R5 rwu_set sleeps", sleeping, 1);
    send_frame(9'h0F0, 1'b0);
    send_frame(9'h011, 1'b0);
    wait_clk(2);
    chk(!rx_full && rx_data == 9'h055, "R5 chars ignored asleep", rx_data, 9'h055);
    chk(sleeping, "R7 still asleep without idle", sleeping, 1);
    wait_clk(12 * BT);
    chk(!sleeping, "R7 idle wakes receiver", sleeping, 0);
    send_frame(9'h0C3, 1'b0);
    wait_clk(2);
    chk(rx_full && rx_data == 9'h0C3, "R1 char after wake", rx_data, 9'h0C3);
    pulse(rd_ack);
    wait_clk(12 * BT);

    // wake_sel=1: idle does not wake
    wake_sel = 1'b1;
    pulse(rwu_set);
    send_frame(9'h0AA, 1'b0);
    wait_clk(12 * BT);
    chk(sleeping && idle_flag, "R7 no wake when wake_sel=1", {sleeping, idle_flag}, 3);
    chk(!rx_full, "R5 ignored with wake_sel=1", rx_full, 0);
    wake_sel = 1'b0;
    send_frame(9'h0AA, 1'b0);
    wait_clk(12 * BT);
    chk(!sleeping, "R7 wake after re-select", sleeping, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule